// File: doc/BRIEF.md
# Multi-channel LED PWM dimmer

This block drives a bank of LED outputs from one clock. Every channel has its own duty register. All channels share one free-running PWM counter, so a channel is high for a number of steps equal to its duty value in every fast period. A shared group duty register produces a slower group signal, which can be ANDed onto any channel. A control bit selects one of two uses for the group signal. In dimming it runs at a fixed rate and scales all gated channels by the same factor. In blinking it runs over a programmable period and switches the gated channels on and off with the group duty as on-time fraction.

Software programs the block through a one-cycle write strobe with a byte address and byte data. The same byte addresses can be read back through a combinational read port. Each channel's behaviour comes from a 2-bit mode input driven from outside the block. Duty values written while a channel is running are held in shadow registers and take effect only at the next period boundary of the counter that uses them. The fast step rate, the dimming step length and the blink step length are set by parameters.

Top module: `led_pwm_dimmer`

## Requirements
- R1: After reset, the registers read as follows. Channel n's duty register is at address 02h+n and reads 0. The group duty register is at 02h+NUM_CH (12h with 16 channels) and reads all ones of DUTY_W bits (FFh for 8 bits, 0Fh for 4 bits). The blink period register is at the next address and reads 0. The control register at 00h reads 0. Every output is low while reset is held.
- R2: A read returns the stored value, zero-extended to 8 bits. Duty registers keep only the low DUTY_W bits of a write, and the control register keeps only bit 0 (1 = blink, 0 = dim). Reads of any other address return 0, and writes to any other address change nothing that can be read back.
- R3: In mode 2'b10, a channel with duty d is high for exactly d×FAST_DIV clocks in each fast period of 2^DUTY_W steps. A duty of 0 keeps the output low.
- R4: The largest duty (all ones) gives (2^DUTY_W−1)/2^DUTY_W high time. An output in mode 2'b10 or 2'b11 is never high for a full fast period.
- R5: Mode 2'b00 forces the output low and mode 2'b01 forces it high, whatever the duty and group settings.
- R6: In dim mode, one group step lasts DIM_PERIODS fast periods and a group period has 2^DUTY_W steps. Over one group period, a channel in mode 2'b11 with duty d and group duty g is high for d×g×DIM_PERIODS×FAST_DIV clocks.
- R7: In blink mode with period register p, one group step lasts (p+1)×BLINK_PERIODS fast periods. Over one blink period, a mode 2'b11 channel is high for d×g×(p+1)×BLINK_PERIODS×FAST_DIV clocks.
- R8: In dim mode the blink period register has no effect on any output.
- R9: A new channel duty takes effect at the next wrap of the fast counter, so the period in progress keeps its old pulse width. Group duty and blink period take effect at the next group counter wrap.
- R10: The group signal changes only at fast period boundaries, so a gated pulse is passed or blocked whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write byte address |
| wrData | input | 8 | Write data |
| rdAddr | input | ADDR_W | Read byte address |
| rdData | output | 8 | Read data for rdAddr, combinational |
| chMode | input | 2*NUM_CH | Per-channel mode, channel n at bits [2n+1:2n] |
| ledOut | output | NUM_CH | Registered LED drive outputs |

## Verification
The hardest case to reach from the ports is a duty write that lands inside a fast period. The shadow register must keep that period's pulse at the old width. The bench locks onto a rising edge of one output, writes a new duty two cycles later, and counts the high samples in that period and in the next one. Group gating is checked with the same kind of whole-period high counts. The bench uses a 4-bit duty width, so complete dim and blink periods are short enough to count exactly. Every channel carries a different duty at the same time, so each count gives the product of individual and group duty for that channel.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

  // Per-channel behaviour selected by the external mode input
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ON    = 2'b01,
    MODE_PWM   = 2'b10,
    MODE_GROUP = 2'b11
  } chMode_e;

  // Strobes passed from the timebase to the datapath
  typedef struct packed {
    logic fastTick;  // fast counter advances this cycle
    logic fastWrap;  // fast counter returns to zero this cycle
    logic grpStep;   // group counter advances this cycle
    logic grpWrap;   // group counter returns to zero this cycle
  } dimStrobe_t;

endpackage

// File: rtl/led_dim_timebase.sv
module led_dim_timebase
  import led_dim_pkg::*;
#(
  parameter int DUTY_W        = 8,
  parameter int FAST_DIV      = 2,
  parameter int DIM_PERIODS   = 2,
  parameter int BLINK_PERIODS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blinkSel,
  input  logic [7:0]        blinkPeriod,
  output dimStrobe_t        strb,
  output logic [DUTY_W-1:0] fastCnt,
  output logic [DUTY_W-1:0] grpCnt
);

  localparam int FAST_PRE_W = $clog2(FAST_DIV + 1);
  localparam int GRP_PRE_W  = $clog2(256 * BLINK_PERIODS + DIM_PERIODS + 2);

  logic [FAST_PRE_W-1:0] fastPre;
  logic [GRP_PRE_W-1:0]  grpPre;
  logic [GRP_PRE_W-1:0]  grpLimit;
  logic                  fastTick, fastWrap, grpStep, grpWrap;

  // Fast step prescaler from the clock
  assign fastTick = (fastPre == FAST_PRE_W'(FAST_DIV - 1));
  assign fastWrap = fastTick && (fastCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastPre <= '0;
      fastCnt <= '0;
    end else begin
      fastPre <= fastTick ? '0 : fastPre + FAST_PRE_W'(1);
      if (fastTick) fastCnt <= fastCnt + DUTY_W'(1);
    end
  end

  // Group step length counted in whole fast periods
  always_comb begin
    if (blinkSel)
      grpLimit = (GRP_PRE_W'(blinkPeriod) + GRP_PRE_W'(1)) * GRP_PRE_W'(BLINK_PERIODS);
    else
      grpLimit = GRP_PRE_W'(DIM_PERIODS);
  end

  assign grpStep = fastWrap && (grpPre >= grpLimit - GRP_PRE_W'(1));
  assign grpWrap = grpStep && (grpCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpPre <= '0;
      grpCnt <= '0;
    end else if (fastWrap) begin
      grpPre <= grpStep ? '0 : grpPre + GRP_PRE_W'(1);
      if (grpStep) grpCnt <= grpCnt + DUTY_W'(1);
    end
  end

  assign strb = '{fastTick: fastTick, fastWrap: fastWrap,
                  grpStep: grpStep, grpWrap: grpWrap};

endmodule

// File: rtl/led_dim_datapath.sv
module led_dim_datapath
  import led_dim_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dimStrobe_t          strb,
  input  logic [DUTY_W-1:0]   fastCnt,
  input  logic [DUTY_W-1:0]   grpCnt,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [7:0]          wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [7:0]          rdData,
  input  logic [2*NUM_CH-1:0] chMode,
  output logic                blinkSel,
  output logic [7:0]          blinkPeriodAct,
  output logic [NUM_CH-1:0]   ledOut
);

  localparam int CTRL_ADDR = 0;
  localparam int DUTY_BASE = 2;
  localparam int GRP_ADDR  = DUTY_BASE + NUM_CH;
  localparam int PER_ADDR  = GRP_ADDR + 1;

  logic [NUM_CH-1:0][DUTY_W-1:0] dutyReg, dutyAct;
  logic [DUTY_W-1:0]             grpReg, grpAct;
  logic [7:0]                    perReg;
  logic [NUM_CH-1:0]             pwmOn;
  logic                          grpOn;

  // Software-visible registers and their shadows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyReg        <= '0;
      dutyAct        <= '0;
      grpReg         <= '1;
      grpAct         <= '1;
      perReg         <= '0;
      blinkPeriodAct <= '0;
      blinkSel       <= 1'b0;
    end else begin
      if (wrEn) begin
        for (int c = 0; c < NUM_CH; c++)
          if (wrAddr == ADDR_W'(DUTY_BASE + c)) dutyReg[c] <= wrData[DUTY_W-1:0];
        if (wrAddr == ADDR_W'(GRP_ADDR))  grpReg   <= wrData[DUTY_W-1:0];
        if (wrAddr == ADDR_W'(PER_ADDR))  perReg   <= wrData;
        if (wrAddr == ADDR_W'(CTRL_ADDR)) blinkSel <= wrData[0];
      end
      if (strb.fastWrap) dutyAct <= dutyReg;
      if (strb.grpWrap) begin
        grpAct         <= grpReg;
        blinkPeriodAct <= perReg;
      end
    end
  end

  // Read mux
  always_comb begin
    rdData = 8'h00;
    for (int c = 0; c < NUM_CH; c++)
      if (rdAddr == ADDR_W'(DUTY_BASE + c)) rdData = 8'(dutyReg[c]);
    if (rdAddr == ADDR_W'(GRP_ADDR))  rdData = 8'(grpReg);
    if (rdAddr == ADDR_W'(PER_ADDR))  rdData = perReg;
    if (rdAddr == ADDR_W'(CTRL_ADDR)) rdData = {7'b0, blinkSel};
  end

  // Per-channel compare
  assign grpOn = (grpCnt < grpAct);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign pwmOn[ch] = (fastCnt < dutyAct[ch]);
  end

  // Output stage, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledOut <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        case (chMode_e'(chMode[2*c +: 2]))
          MODE_OFF:   ledOut[c] <= 1'b0;
          MODE_ON:    ledOut[c] <= 1'b1;
          MODE_PWM:   ledOut[c] <= pwmOn[c];
          MODE_GROUP: ledOut[c] <= pwmOn[c] & grpOn;
          default:    ledOut[c] <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/led_pwm_dimmer.sv
module led_pwm_dimmer
  import led_dim_pkg::*;
#(
  parameter int NUM_CH        = 16,
  parameter int DUTY_W        = 8,
  parameter int ADDR_W        = 5,
  parameter int FAST_DIV      = 2,
  parameter int DIM_PERIODS   = 2,
  parameter int BLINK_PERIODS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [7:0]          wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [7:0]          rdData,
  input  logic [2*NUM_CH-1:0] chMode,
  output logic [NUM_CH-1:0]   ledOut
);

  dimStrobe_t        strb;
  logic [DUTY_W-1:0] fastCnt, grpCnt;
  logic              blinkSel;
  logic [7:0]        blinkPeriodAct;

  led_dim_timebase #(
    .DUTY_W(DUTY_W), .FAST_DIV(FAST_DIV),
    .DIM_PERIODS(DIM_PERIODS), .BLINK_PERIODS(BLINK_PERIODS)
  ) i_timebase (
    .clk(clk), .rstN(rstN), .blinkSel(blinkSel), .blinkPeriod(blinkPeriodAct),
    .strb(strb), .fastCnt(fastCnt), .grpCnt(grpCnt)
  );

  led_dim_datapath #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .fastCnt(fastCnt), .grpCnt(grpCnt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .chMode(chMode), .blinkSel(blinkSel), .blinkPeriodAct(blinkPeriodAct), .ledOut(ledOut)
  );

endmodule

// File: rtl/led_dim_checker.sv
module led_dim_checker
  import led_dim_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [2*NUM_CH-1:0] chMode,
  input logic [NUM_CH-1:0]   ledOut,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [7:0]          rdData,
  input dimStrobe_t          strb,
  input logic [DUTY_W-1:0]   fastCnt,
  input logic [DUTY_W-1:0]   grpCnt
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $past(chMode[2*ch +: 2]) == 2'b00) |-> !ledOut[ch]);  // R5
    AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $past(chMode[2*ch +: 2]) == 2'b01) |-> ledOut[ch]);  // R5
    AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $past(chMode[2*ch+1]) && $past(fastCnt) == '1) |-> !ledOut[ch]);  // R4
  end

  AST_GROUP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strb.grpStep |-> strb.fastWrap);  // R10

  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fastWrap |=> $stable(grpCnt));  // R10

  AST_FAST_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fastTick |=> fastCnt == DUTY_W'($past(fastCnt) + DUTY_W'(1)));  // R3

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(1) || rdAddr > ADDR_W'(NUM_CH + 3)) |-> rdData == 8'h00);  // R2

endmodule

bind led_pwm_dimmer led_dim_checker #(
  .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .chMode(chMode), .ledOut(ledOut), .rdAddr(rdAddr),
  .rdData(rdData), .strb(strb), .fastCnt(fastCnt), .grpCnt(grpCnt)
);

// File: tb/test_led_pwm_dimmer.sv
module test_led_pwm_dimmer;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 16;
  localparam int DUTY_W     = 4;
  localparam int ADDR_W     = 5;
  localparam int STEPS      = 1 << DUTY_W;
  localparam int GRP_ADDR   = 2 + NUM_CH;
  localparam int PER_ADDR   = GRP_ADDR + 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wrEn = 1'b0;
  logic [ADDR_W-1:0]   wrAddr = '0;
  logic [7:0]          wrData = '0;
  logic [ADDR_W-1:0]   rdAddr = '0;
  logic [7:0]          rdData;
  logic [2*NUM_CH-1:0] chMode = '0;
  logic [NUM_CH-1:0]   ledOut;

  int checks = 0;
  int fails  = 0;
  int cnt [NUM_CH];
  int model [32];

  led_pwm_dimmer #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W),
    .FAST_DIV(1), .DIM_PERIODS(1), .BLINK_PERIODS(1)
  ) i_led_pwm_dimmer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .chMode(chMode), .ledOut(ledOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Write a register and update the bench model from the register rules
  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 0)                         model[a] = d & 1;
    else if (a >= 2 && a < 2 + NUM_CH) model[a] = d & (STEPS - 1);
    else if (a == GRP_ADDR)             model[a] = d & (STEPS - 1);
    else if (a == PER_ADDR)             model[a] = d & 255;
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      rdAddr = ADDR_W'(a);
      #1;
      check(rdData == 8'(model[a]), req, int'(rdData), model[a]);
    end
  endtask

  task automatic countAll(input int n);
    for (int c = 0; c < NUM_CH; c++) cnt[c] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) cnt[c] += int'(ledOut[c]);
    end
  endtask

  task automatic setModes(input logic [1:0] m);
    @(negedge clk);
    chMode = {NUM_CH{m}};
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) model[a] = 0;
    model[GRP_ADDR] = STEPS - 1;
    chMode = {NUM_CH{2'b01}};
    repeat (3) @(negedge clk);
    check(ledOut == '0, "R1 outputs low in reset", int'(ledOut), 0);
    rstN = 1'b1;
    setModes(2'b10);

    // R1: reset register values
    readAll("R1 reset value");

    // R2: unmapped writes ignored, field truncation
    wrReg(1, 8'hAA);
    for (int a = PER_ADDR + 1; a < 32; a++) wrReg(a, 8'h5C);
    wrReg(0, 8'hFE);
    wrReg(2, 8'h3C);
    wrReg(GRP_ADDR, 8'hA7);
    wrReg(PER_ADDR, 8'h05);
    readAll("R2 readback");
    wrReg(GRP_ADDR, STEPS - 1);

    // R3/R4: individual PWM sweep, two patterns
    for (int c = 0; c < NUM_CH; c++) wrReg(2 + c, c);
    repeat (2 * STEPS) @(negedge clk);
    countAll(STEPS);
    for (int c = 0; c < NUM_CH; c++) check(cnt[c] == c, "R3 ascending duty", cnt[c], c);
    for (int c = 0; c < NUM_CH; c++) wrReg(2 + c, STEPS - 1 - c);
    repeat (2 * STEPS) @(negedge clk);
    countAll(4 * STEPS);
    for (int c = 0; c < NUM_CH; c++)
      check(cnt[c] == 4 * (STEPS - 1 - c), "R3 descending duty", cnt[c], 4 * (STEPS - 1 - c));
    check(cnt[0] == 4 * (STEPS - 1), "R4 max duty short of full", cnt[0], 4 * (STEPS - 1));

    // R5: forced modes
    setModes(2'b00);
    countAll(2 * STEPS);
    for (int c = 0; c < NUM_CH; c++) check(cnt[c] == 0, "R5 mode 00 low", cnt[c], 0);
    setModes(2'b01);
    countAll(2 * STEPS);
    for (int c = 0; c < NUM_CH; c++) check(cnt[c] == 2 * STEPS, "R5 mode 01 high", cnt[c], 2 * STEPS);

    // R6/R8/R10: dimming, blink period register left at 5
    for (int c = 0; c < NUM_CH; c++) wrReg(2 + c, c);
    setModes(2'b11);
    foreach (model[i]) if (i == 99) model[i] = 0;
    for (int gi = 0; gi < 4; gi++) begin
      int g;
      g = (gi == 0) ? 0 : (gi == 1) ? 1 : (gi == 2) ? 5 : STEPS - 1;
      wrReg(GRP_ADDR, g);
      repeat (2 * STEPS * STEPS + 32) @(negedge clk);
      countAll(STEPS * STEPS);
      for (int c = 0; c < NUM_CH; c++)
        check(cnt[c] == c * g, "R6 dim product", cnt[c], c * g);
      if (g == 1) check(cnt[NUM_CH-1] == NUM_CH - 1, "R10 whole pulses gated", cnt[NUM_CH-1], NUM_CH - 1);
      if (g == 5) check(cnt[7] == 35, "R8 period ignored in dim", cnt[7], 35);
    end

    // R7: blink with several periods
    wrReg(GRP_ADDR, 6);
    wrReg(0, 1);
    for (int p = 0; p < 3; p++) begin
      wrReg(PER_ADDR, p);
      repeat (STEPS * STEPS * (2 * p + 5)) @(negedge clk);
      countAll(STEPS * STEPS * (p + 1));
      for (int c = 0; c < NUM_CH; c++)
        check(cnt[c] == c * 6 * (p + 1), "R7 blink product", cnt[c], c * 6 * (p + 1));
    end
    wrReg(0, 0);

    // R9: duty write inside a running fast period
    setModes(2'b10);
    wrReg(2, 8);
    repeat (3 * STEPS) @(negedge clk);
    begin
      logic prev;
      int ones, guard;
      guard = 0;
      prev = ledOut[0];
      @(negedge clk);
      while (!(!prev && ledOut[0]) && guard < 4 * STEPS) begin
        prev = ledOut[0];
        guard++;
        @(negedge clk);
      end
      ones = 1;
      for (int i = 1; i < STEPS; i++) begin
        @(negedge clk);
        if (i == 2) begin wrEn = 1'b1; wrAddr = ADDR_W'(2); wrData = 8'd2; end
        else if (i == 3) wrEn = 1'b0;
        ones += int'(ledOut[0]);
      end
      model[2] = 2;
      check(ones == 8, "R9 running period keeps old duty", ones, 8);
      ones = 0;
      for (int i = 0; i < STEPS; i++) begin
        @(negedge clk);
        ones += int'(ledOut[0]);
      end
      check(ones == 2, "R9 new duty after wrap", ones, 2);
    end

    readAll("R2 final readback");
    summary();
    $finish;
  end

endmodule